// File: doc/BRIEF.md
# Comparator event interrupt controller

This block is the digital side of an analog comparator. The comparator's raw output arrives with no timing relation to the clock. The block passes it through a two-stage synchronizer and watches the synchronized value for the kind of transition chosen by a 2-bit mode field. A detected transition sets a sticky interrupt flag. The flag raises an interrupt request only while the local enable bit and the global interrupt enable input are both high.

Software reaches the block through one 8-bit control/status register on a simple bus, made of a write strobe, write data and combinational read data. An acknowledge input from the interrupt vector logic clears the flag. Writing a one to the flag's bit position clears it too. The block also drives three control outputs. One powers down the comparator. One selects the internal fixed reference for the comparator's positive input. The third forwards the synchronized result to a timer's capture trigger.

Top module: `cmp_irq_ctrl`

## Requirements
- R1: After reset every writable register bit is 0, the read data is 8'h00, and irq_o, cmp_off_o, ref_int_sel_o and cap_trig_o are all 0.
- R2: The read data layout from bit 7 to bit 0 is: comparator off, internal reference select, synchronized result, event flag, interrupt enable, capture route, mode[1], mode[0]. A write with bus_wr_i high loads bits 7, 6, 3, 2, 1 and 0 from bus_wdata_i.
- R3: Bit 5 of the read data is the synchronized result. It equals the raw input gated by the off bit, sampled two rising clock edges earlier. A write has no effect on bit 5.
- R4: With mode 2'b00, every change of the synchronized result sets the flag on the next clock edge.
- R5: Mode 2'b11 sets the flag only on a 0-to-1 change of the synchronized result. Mode 2'b10 sets it only on a 1-to-0 change. Mode 2'b01 never sets it.
- R6: A write with bus_wdata_i[4] = 1 clears the flag. A write with bus_wdata_i[4] = 0 leaves the flag unchanged.
- R7: vec_ack_i high at a clock edge clears the flag.
- R8: If an event and a clear (by write or by acknowledge) happen in the same cycle, the flag ends up set.
- R9: irq_o is 1 exactly when the flag, the interrupt enable bit and global_ie_i are all 1.
- R10: cmp_off_o follows register bit 7 and ref_int_sel_o follows register bit 6.
- R11: cap_trig_o equals the synchronized result while the capture route bit (bit 2) is 1, and is 0 while that bit is 0.
- R12: While the off bit is 1, the synchronizer input is forced to 0 and no event sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw_i | input | 1 | Raw asynchronous comparator result |
| bus_wr_i | input | 1 | Register write strobe |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data |
| vec_ack_i | input | 1 | Interrupt vector acknowledge, clears the flag |
| global_ie_i | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Interrupt request |
| cmp_off_o | output | 1 | Comparator power-down |
| ref_int_sel_o | output | 1 | Positive input select: 1 internal reference, 0 external pin |
| cap_trig_o | output | 1 | Synchronized result routed to the timer capture trigger |

## Verification
The bench holds acknowledge or a write-one clear high across the cycle in which an edge is detected. A design that gave the clear priority would drop that event, and the flag would read 0 where 1 is expected. Transitions are driven in each mode, including the reserved code, so a swapped rising/falling decode or an event from the reserved mode shows up as a wrong flag. The bench also switches the off bit while the input is high, and it writes ones to the read-only result bit. A synchronizer that ignores the off bit, or a result bit that latches written data, then gives a mismatch at bit 5 or at cap_trig_o.

// File: rtl/cmpirq_pkg.sv
package cmpirq_pkg;

  localparam int REG_W   = 8;
  localparam int B_OFF   = 7;
  localparam int B_REF   = 6;
  localparam int B_SYNC  = 5;
  localparam int B_FLAG  = 4;
  localparam int B_IE    = 3;
  localparam int B_ROUTE = 2;
  localparam int B_MODE1 = 1;
  localparam int B_MODE0 = 0;

  typedef enum logic [1:0] {
    EV_TOGGLE = 2'b00,
    EV_NONE   = 2'b01,
    EV_FALL   = 2'b10,
    EV_RISE   = 2'b11
  } ev_mode_e;

  // Decide whether a transition prev -> cur counts as an event under mode m
  function automatic logic edge_hit(ev_mode_e m, logic prev, logic cur);
    logic hit;
    case (m)
      EV_TOGGLE: hit = prev ^ cur;
      EV_FALL:   hit = prev & ~cur;
      EV_RISE:   hit = ~prev & cur;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/cmpirq_sync.sv
module cmpirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic force_low_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;
  logic              sample_in;

  // R12: gated input while the comparator is off
  assign sample_in = raw_i & ~force_low_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], sample_in};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/cmpirq_edge.sv
module cmpirq_edge
  import cmpirq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sync_i,
  input  ev_mode_e mode_i,
  input  logic     suppress_i,
  output logic     evt_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_i;
  end

  assign evt_o = ~suppress_i & edge_hit(mode_i, prev_q, sync_i);

  // R5: the reserved mode never yields an event
  a_r5_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == EV_NONE) |-> !evt_o);
endmodule

// File: rtl/cmpirq_flag.sv
module cmpirq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_wr_i,
  input  logic clr_ack_i,
  output logic flag_o
);
  logic flag_q;

  // R8: set dominates either clear source
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    flag_q <= 1'b0;
    else if (set_i)                flag_q <= 1'b1;
    else if (clr_wr_i | clr_ack_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  a_r6_write_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr_i && !set_i) |=> !flag_o);
  a_r7_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ack_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/cmp_irq_ctrl.sv
module cmp_irq_ctrl
  import cmpirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_raw_i,
  input  logic             bus_wr_i,
  input  logic [REG_W-1:0] bus_wdata_i,
  output logic [REG_W-1:0] bus_rdata_o,
  input  logic             vec_ack_i,
  input  logic             global_ie_i,
  output logic             irq_o,
  output logic             cmp_off_o,
  output logic             ref_int_sel_o,
  output logic             cap_trig_o
);
  logic     off_q, ref_q, ie_q, route_q;
  ev_mode_e mode_q;
  logic     sync_w, evt_w, flag_w, clr_wr_w;

  // R2 R10: writable control bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q   <= 1'b0;
      ref_q   <= 1'b0;
      ie_q    <= 1'b0;
      route_q <= 1'b0;
      mode_q  <= EV_TOGGLE;
    end else if (bus_wr_i) begin
      off_q   <= bus_wdata_i[B_OFF];
      ref_q   <= bus_wdata_i[B_REF];
      ie_q    <= bus_wdata_i[B_IE];
      route_q <= bus_wdata_i[B_ROUTE];
      mode_q  <= ev_mode_e'({bus_wdata_i[B_MODE1], bus_wdata_i[B_MODE0]});
    end
  end

  cmpirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(cmp_raw_i),
    .force_low_i(off_q), .sync_o(sync_w)
  );

  cmpirq_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_w), .mode_i(mode_q),
    .suppress_i(off_q), .evt_o(evt_w)
  );

  assign clr_wr_w = bus_wr_i & bus_wdata_i[B_FLAG];

  cmpirq_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(evt_w), .clr_wr_i(clr_wr_w),
    .clr_ack_i(vec_ack_i), .flag_o(flag_w)
  );

  always_comb begin
    bus_rdata_o          = '0;
    bus_rdata_o[B_OFF]   = off_q;
    bus_rdata_o[B_REF]   = ref_q;
    bus_rdata_o[B_SYNC]  = sync_w;
    bus_rdata_o[B_FLAG]  = flag_w;
    bus_rdata_o[B_IE]    = ie_q;
    bus_rdata_o[B_ROUTE] = route_q;
    bus_rdata_o[B_MODE1] = mode_q[1];
    bus_rdata_o[B_MODE0] = mode_q[0];
  end

  assign irq_o         = flag_w & ie_q & global_ie_i;
  assign cmp_off_o     = off_q;
  assign ref_int_sel_o = ref_q;
  assign cap_trig_o    = route_q & sync_w;

  // R12: with the comparator off and no clear, the flag holds
  a_r12_off_holds_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q && !vec_ack_i && !clr_wr_w) |=> (flag_w == $past(flag_w)));

  // R4: any change of the synchronized result sets the flag in toggle mode
  a_r4_toggle_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == EV_TOGGLE && !off_q && sync_w != $past(sync_w)) |=> flag_w);

  // R5: a rising result sets the flag in rising mode
  a_r5_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == EV_RISE && !off_q && $rose(sync_w)) |=> flag_w);

  // R12: the synchronizer output is low two edges after the comparator was off
  if (SYNC_STAGES == 2) begin : g_sync_chk
    a_r12_sync_forced_low: assert property (@(posedge clk) disable iff (!rst_n)
      $past(off_q, 2) |-> !sync_w);
  end
endmodule

// File: tb/tb_cmp_irq_ctrl.sv
module tb_cmp_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmp_raw_i, bus_wr_i, vec_ack_i, global_ie_i;
  logic [7:0] bus_wdata_i, bus_rdata_o;
  logic       irq_o, cmp_off_o, ref_int_sel_o, cap_trig_o;

  int n_chk = 0;
  int n_fail = 0;

  // bench model state
  logic m_s1, m_s2, m_prev, m_flag, m_off, m_ref, m_ie, m_route;
  logic [1:0] m_mode;
  logic m_gie;

  always #10 clk = ~clk;

  cmp_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmp_raw_i(cmp_raw_i), .bus_wr_i(bus_wr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .vec_ack_i(vec_ack_i),
    .global_ie_i(global_ie_i), .irq_o(irq_o), .cmp_off_o(cmp_off_o),
    .ref_int_sel_o(ref_int_sel_o), .cap_trig_o(cap_trig_o)
  );

  // event rule written from R4/R5
  function automatic logic exp_event(logic [1:0] mode, logic was, logic now);
    if (mode == 2'b00) return was != now;
    if (mode == 2'b11) return (was == 1'b0) && (now == 1'b1);
    if (mode == 2'b10) return (was == 1'b1) && (now == 1'b0);
    return 1'b0;
  endfunction

  function automatic logic [7:0] exp_rd();
    return {m_off, m_ref, m_s2, m_flag, m_ie, m_route, m_mode};
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [7:0] e;
    e = exp_rd();
    check("R2 R3 control bits and result", {bus_rdata_o[7:5], bus_rdata_o[3:0], 1'b0},
          {e[7:5], e[3:0], 1'b0});
    check("R4 R5 R6 R7 R8 R12 flag", {7'd0, bus_rdata_o[4]}, {7'd0, e[4]});
    check("R9 irq", {7'd0, irq_o}, {7'd0, m_flag & m_ie & m_gie});
    check("R10 off/ref outputs", {6'd0, cmp_off_o, ref_int_sel_o}, {6'd0, m_off, m_ref});
    check("R11 capture trigger", {7'd0, cap_trig_o}, {7'd0, m_route & m_s2});
  endtask

  // one clock: drive at negedge, update model at posedge, sample 5 ns later
  task automatic step(input logic raw, input logic wr, input logic [7:0] wd,
                      input logic ack, input logic gie);
    logic in_v, ev_v, clr_v;
    @(negedge clk);
    cmp_raw_i = raw; bus_wr_i = wr; bus_wdata_i = wd; vec_ack_i = ack; global_ie_i = gie;
    @(posedge clk);
    in_v  = raw & ~m_off;
    ev_v  = ~m_off & exp_event(m_mode, m_prev, m_s2);
    clr_v = ack | (wr & wd[4]);
    if (ev_v) m_flag = 1'b1;
    else if (clr_v) m_flag = 1'b0;
    m_prev = m_s2; m_s2 = m_s1; m_s1 = in_v;
    if (wr) begin
      m_off = wd[7]; m_ref = wd[6]; m_ie = wd[3]; m_route = wd[2]; m_mode = wd[1:0];
    end
    m_gie = gie;
    #5;
    check_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmp_raw_i = 1'b0; bus_wr_i = 1'b0; bus_wdata_i = 8'h00; vec_ack_i = 1'b0; global_ie_i = 1'b0;
    {m_s1, m_s2, m_prev, m_flag, m_off, m_ref, m_ie, m_route} = '0;
    m_mode = 2'b00; m_gie = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1: reset state
    check("R1 reset read data", bus_rdata_o, 8'h00);
    check("R1 reset outputs", {4'd0, irq_o, cmp_off_o, ref_int_sel_o, cap_trig_o}, 8'h00);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic r;
    seed = 32'd7331;
    void'($urandom(seed));
    rst_n = 1'b0;
    do_reset();

    // R4: toggle mode, ie on, global enable on
    step(0, 1, 8'h08, 0, 1);
    step(1, 0, 8'h00, 0, 1);
    repeat (3) step(1, 0, 8'h00, 0, 1);
    step(1, 1, 8'h18, 0, 1);   // R6: write-1 clears
    repeat (2) step(1, 1, 8'h08, 0, 1); // R6: write-0 leaves flag
    step(0, 0, 8'h00, 0, 1);
    repeat (3) step(0, 0, 8'h00, 0, 0); // R9: global enable low
    step(0, 0, 8'h00, 1, 1);   // R7: acknowledge clears

    // R5: rising mode then falling then reserved
    step(0, 1, 8'h0B, 0, 1);
    repeat (3) step(1, 0, 8'h00, 0, 1);
    step(1, 0, 8'h00, 1, 1);
    repeat (3) step(0, 0, 8'h00, 0, 1); // falling ignored in rising mode
    step(0, 1, 8'h0A, 0, 1);
    repeat (3) step(1, 0, 8'h00, 0, 1); // rising ignored in falling mode
    repeat (3) step(0, 0, 8'h00, 0, 1);
    step(0, 1, 8'h19, 0, 1);   // reserved mode, clear flag
    repeat (3) step(1, 0, 8'h00, 0, 1);
    repeat (3) step(0, 0, 8'h00, 0, 1);

    // R8: clear held through the event cycle
    step(0, 1, 8'h08, 0, 1);
    step(1, 0, 8'h00, 1, 1);
    repeat (3) step(1, 0, 8'h00, 1, 1);
    step(0, 1, 8'h18, 0, 1);
    step(0, 1, 8'h18, 0, 1);
    step(0, 1, 8'h18, 0, 1);

    // R3 R11: write ones to bit 5, route to capture
    step(1, 1, 8'h24, 0, 1);
    repeat (3) step(1, 1, 8'h24, 0, 1);
    step(0, 1, 8'h20, 0, 1);
    repeat (3) step(0, 0, 8'h00, 0, 1);

    // R12 R10: comparator off while raw is high
    step(1, 1, 8'h44, 1, 1);
    repeat (3) step(1, 0, 8'h00, 0, 1);
    step(1, 1, 8'hC4, 1, 1);
    repeat (4) step(1, 0, 8'h00, 0, 1);
    step(0, 0, 8'h00, 0, 1);
    step(1, 1, 8'h04, 0, 1);
    repeat (4) step(1, 0, 8'h00, 0, 1);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic wr, ack, gie;
      logic [7:0] wd;
      r   = ($urandom % 4 == 0) ? ~cmp_raw_i : cmp_raw_i;
      wr  = ($urandom % 10 == 0);
      wd  = 8'($urandom);
      if ($urandom % 4 != 0) wd[7] = 1'b0;
      ack = ($urandom % 8 == 0);
      gie = ($urandom % 5 != 0);
      step(r, wr, wd, ack, gie);
    end

    do_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule